// File: doc/BRIEF.md
# Lockable Instruction Cache Controller

This block sits between a core's instruction fetch port and a slow instruction memory. It holds a small two-way set-associative store of 32-bit instruction words. Each line carries a lock bit that keeps it from being evicted, so a routine that matters can be pinned on chip and served at full speed, much like fast on-chip ROM. A single byte-wide control register turns the cache on and off and drives the locking features. Lines can be locked in three ways: every valid line at once, each line filled while a fill-lock mode is on, or all locks released in one write.

Fetch and memory addresses are word addresses. The low `SET_W` bits pick the set and the remaining upper bits form the tag. A hit returns data one cycle after the request. A miss, or any fetch made while the cache is off, issues a memory read and waits for the memory to signal ready, whatever its wait-state count. The register port is a simple write strobe with a combinational read. It answers only at address 0x3E7.

Top module: `icache_lock_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the cache is off, and the first fetch issues a memory read.
- R2: While control bit 0 is 0, every fetch issues a memory read, returns the memory word, and fills no line, so the first fetch after enabling is a miss.
- R3: With bit 0 set, a fetch that hits raises fetch_ready exactly one cycle after the request with the stored word, and raises no memory read.
- R4: mem_req stays high until mem_ready is seen. fetch_ready follows one cycle later carrying the memory word, for any number of wait states.
- R5: At address 0x3E7 the register reads back the last written byte with bit 2 forced to 0. Other addresses read 0x00, and writes to them leave the register unchanged.
- R6: A write to the register with bits 5 and 0 both set locks every line that is valid at that moment.
- R7: While bits 3 and 0 are both set, each line filled on a miss is stored locked. Lines filled after bit 3 is cleared are unlocked.
- R8: A write with bit 2 set clears every lock bit. This takes priority over bit 5 in the same write.
- R9: The miss victim is chosen from the unlocked ways. An invalid way is taken first, otherwise the least recently used way of the set. A locked line is never replaced.
- R10: When both ways of the set are locked, a miss returns the memory word to the core and changes no line, so the same address misses again.
- R11: Clearing bit 0 keeps the stored lines, and after bit 0 is set again those lines hit.
- R12: fetch_ready is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Core fetch request, held until fetch_ready |
| fetch_addr | input | WORD_AW | Word address of the instruction |
| fetch_ready | output | 1 | One-cycle pulse, fetch_data valid |
| fetch_data | output | DATA_W | Instruction word returned to the core |
| mem_req | output | 1 | Read request to instruction memory |
| mem_addr | output | WORD_AW | Word address of the memory read |
| mem_ready | input | 1 | Memory read data valid this cycle |
| mem_data | input | DATA_W | Memory read data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |

## Verification
Fetch streams are driven into one set with three or more competing tags. These sequences tell true LRU victim choice apart from fixed-way or invalid-blind choice: an address that should survive must hit, and one that should have been evicted must miss. The same conflict patterns are then repeated after a global lock, during fill-lock mode, and after a combined lock-and-release write. The outcome, hit or miss, shows whether the lock bits were set, ignored or cleared. Memory wait states vary from fetch to fetch, so the handshake is exercised at several latencies. Bypass fetches made while the cache is off are followed by a re-enable, to tell bypass apart from silent filling.

// File: rtl/icache_lock_ctrl.sv
module icache_lock_ctrl #(
  parameter int WORD_AW = 14,
  parameter int DATA_W  = 32,
  parameter int SETS    = 16,
  parameter int REG_AW  = 12,
  parameter logic [REG_AW-1:0] CTRL_ADDR = 12'h3E7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_req,
  input  logic [WORD_AW-1:0] fetch_addr,
  output logic               fetch_ready,
  output logic [DATA_W-1:0]  fetch_data,
  output logic               mem_req,
  output logic [WORD_AW-1:0] mem_addr,
  input  logic               mem_ready,
  input  logic [DATA_W-1:0]  mem_data,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata
);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = WORD_AW - SET_W;

  typedef enum logic {S_IDLE, S_MISS} state_t;

  state_t              st_q;
  logic                rdy_q, mreq_q, mfill_q;
  logic [WORD_AW-1:0]  maddr_q;
  logic [DATA_W-1:0]   data_q;
  logic [7:0]          ctrl_q;
  logic [SETS-1:0]     lru_q;
  logic [SETS-1:0]     vld_q [2];
  logic [SETS-1:0]     lck_q [2];
  logic [SETS-1:0]     vld_d [2];
  logic [SETS-1:0]     lck_d [2];
  logic [TAG_W-1:0]    tag_q [2][SETS];
  logic [DATA_W-1:0]   dat_q [2][SETS];

  wire en     = ctrl_q[0];
  wire wr_ctl = reg_wr && (reg_addr == CTRL_ADDR);
  wire glob   = wr_ctl && reg_wdata[5] && reg_wdata[0];
  wire rel    = wr_ctl && reg_wdata[2];

  wire [SET_W-1:0] set_i = fetch_addr[SET_W-1:0];
  wire [TAG_W-1:0] tag_i = fetch_addr[WORD_AW-1:SET_W];
  wire hit0 = vld_q[0][set_i] && (tag_q[0][set_i] == tag_i);
  wire hit1 = vld_q[1][set_i] && (tag_q[1][set_i] == tag_i);
  wire hit  = en && (hit0 || hit1);
  wire take = (st_q == S_IDLE) && fetch_req && !rdy_q;

  wire [SET_W-1:0] fs = maddr_q[SET_W-1:0];
  wire l0 = lck_q[0][fs];
  wire l1 = lck_q[1][fs];
  logic vway;
  always_comb begin
    if (l0)                vway = 1'b1;
    else if (l1)           vway = 1'b0;
    else if (!vld_q[0][fs]) vway = 1'b0;
    else if (!vld_q[1][fs]) vway = 1'b1;
    else                   vway = lru_q[fs];
  end
  wire fill_go   = (st_q == S_MISS) && mem_ready && mfill_q && !(l0 && l1);
  wire fill_lock = ctrl_q[3] && ctrl_q[0];

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      vld_d[w] = vld_q[w];
      lck_d[w] = lck_q[w];
    end
    if (fill_go) begin
      vld_d[vway][fs] = 1'b1;
      lck_d[vway][fs] = fill_lock;
    end
    for (int w = 0; w < 2; w++) begin
      if (glob) lck_d[w] = lck_d[w] | vld_d[w];
      if (rel)  lck_d[w] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rdy_q   <= 1'b0;
      mreq_q  <= 1'b0;
      mfill_q <= 1'b0;
      maddr_q <= '0;
      data_q  <= '0;
      ctrl_q  <= '0;
      lru_q   <= '0;
      for (int w = 0; w < 2; w++) begin
        vld_q[w] <= '0;
        lck_q[w] <= '0;
      end
    end else begin
      rdy_q <= 1'b0;
      for (int w = 0; w < 2; w++) begin
        vld_q[w] <= vld_d[w];
        lck_q[w] <= lck_d[w];
      end
      if (wr_ctl) ctrl_q <= reg_wdata & 8'hFB;
      case (st_q)
        S_IDLE: if (take) begin
          if (hit) begin
            rdy_q        <= 1'b1;
            data_q       <= hit1 ? dat_q[1][set_i] : dat_q[0][set_i];
            lru_q[set_i] <= !hit1;
          end else begin
            st_q    <= S_MISS;
            mreq_q  <= 1'b1;
            maddr_q <= fetch_addr;
            mfill_q <= en;
          end
        end
        S_MISS: if (mem_ready) begin
          mreq_q <= 1'b0;
          rdy_q  <= 1'b1;
          data_q <= mem_data;
          st_q   <= S_IDLE;
          if (fill_go) lru_q[fs] <= !vway;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      tag_q[vway][fs] <= maddr_q[WORD_AW-1:SET_W];
      dat_q[vway][fs] <= mem_data;
    end
  end

  assign fetch_ready = rdy_q;
  assign fetch_data  = data_q;
  assign mem_req     = mreq_q;
  assign mem_addr    = maddr_q;
  assign reg_rdata   = (reg_addr == CTRL_ADDR) ? ctrl_q : 8'h00;

  // R12
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |=> !fetch_ready);
  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr));
  // R8
  lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && reg_wdata[2] |=> (lck_q[0] == '0) && (lck_q[1] == '0));
  // R9
  locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |-> !lck_q[vway][fs]);
  // R3
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && hit |=> fetch_ready && !mem_req);
  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !en |=> mem_req && !fetch_ready);
endmodule

// File: tb/icache_lock_ctrl_tb_top.sv
module icache_lock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [13:0] fetch_addr = '0;
  logic        fetch_ready;
  logic [31:0] fetch_data;
  logic        mem_req;
  logic [13:0] mem_addr;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_data;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = 12'h3E7;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;

  int checks = 0;
  int fails  = 0;
  int wait_cfg = 0;
  int mcnt = 0;
  int cyc_all = 0;

  always #2 clk = ~clk;

  icache_lock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_data(mem_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] word_of(logic [13:0] a);
    return {~{2'b00, a}, {2'b00, a}};
  endfunction

  assign mem_data = word_of(mem_addr);

  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready <= 1'b0;
      mcnt      <= 0;
    end else if (mem_req) begin
      if (mcnt >= wait_cfg) mem_ready <= 1'b1;
      else mcnt <= mcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [13:0] a, output logic [31:0] d,
                          output bit used, output int cyc);
    used = 0;
    cyc  = 0;
    @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    do begin
      @(negedge clk);
      cyc++;
      if (mem_req) used = 1;
    end while (!fetch_ready && cyc < 500);
    d = fetch_data;
    fetch_req = 1'b0;
    if (!fetch_ready) chk(0, "R4", "fetch timeout", 32'(cyc), 32'd500);
  endtask

  task automatic expect_fetch(input logic [13:0] a, input bit exp_hit,
                              input string req);
    logic [31:0] d;
    bit used;
    int cyc;
    do_fetch(a, d, used, cyc);
    chk(d == word_of(a), req, "fetch data", d, word_of(a));
    chk(used == !exp_hit && (!exp_hit || cyc == 1), req, "hit flag",
        32'(!used), 32'(exp_hit));
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 12'h3E7;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 12'h3E7;
  endtask

  // {word address, expected hit}; set 1 conflict stream then set 2
  localparam logic [14:0] VEC [11] = '{
    {14'h011, 1'b0}, {14'h011, 1'b1}, {14'h021, 1'b0}, {14'h011, 1'b1},
    {14'h031, 1'b0}, {14'h011, 1'b1}, {14'h021, 1'b0}, {14'h011, 1'b1},
    {14'h031, 1'b0}, {14'h002, 1'b0}, {14'h002, 1'b1}
  };

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc_all);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(12'h3E7, rd);
    chk(rd == 8'h00, "R1", "ctrl after reset", 32'(rd), 32'h0);
    expect_fetch(14'h004, 1'b0, "R1");
    @(negedge clk);
    chk(!fetch_ready, "R12", "ready pulse width", 32'(fetch_ready), 32'h0);

    // R5 register readback
    reg_write(12'h3E7, 8'hDF);
    reg_read(12'h3E7, rd);
    chk(rd == 8'hDB, "R5", "readback bit2 cleared", 32'(rd), 32'hDB);
    reg_write(12'h3E7, 8'h00);
    reg_write(12'h3E6, 8'h01);
    reg_read(12'h3E7, rd);
    chk(rd == 8'h00, "R5", "foreign write ignored", 32'(rd), 32'h0);
    reg_read(12'h3E6, rd);
    chk(rd == 8'h00, "R5", "foreign address reads 0", 32'(rd), 32'h0);

    // R2 bypass while off, no fill
    expect_fetch(14'h004, 1'b0, "R2");
    expect_fetch(14'h004, 1'b0, "R2");
    reg_write(12'h3E7, 8'h01);
    expect_fetch(14'h004, 1'b0, "R2");

    // R3 R9 R4 table walk, varying wait states
    for (int i = 0; i < 11; i++) begin
      wait_cfg = i % 4;
      expect_fetch(VEC[i][14:1], VEC[i][0], "R3/R9/R4");
    end
    wait_cfg = 2;

    // R11 disable keeps lines
    reg_write(12'h3E7, 8'h00);
    expect_fetch(14'h011, 1'b0, "R11");
    reg_write(12'h3E7, 8'h01);
    expect_fetch(14'h011, 1'b1, "R11");

    // R6 global lock, R10 both ways locked
    reg_write(12'h3E7, 8'h21);
    expect_fetch(14'h021, 1'b0, "R10");
    expect_fetch(14'h021, 1'b0, "R10");
    expect_fetch(14'h011, 1'b1, "R6");
    expect_fetch(14'h031, 1'b1, "R6");

    // R8 release after disable
    reg_write(12'h3E7, 8'h00);
    reg_write(12'h3E7, 8'h04);
    reg_write(12'h3E7, 8'h01);
    expect_fetch(14'h021, 1'b0, "R8");
    expect_fetch(14'h021, 1'b1, "R8");

    // R7 lock on fill, set 5
    reg_write(12'h3E7, 8'h09);
    expect_fetch(14'h015, 1'b0, "R7");
    reg_write(12'h3E7, 8'h01);
    expect_fetch(14'h025, 1'b0, "R7");
    expect_fetch(14'h035, 1'b0, "R9");
    expect_fetch(14'h015, 1'b1, "R7");
    expect_fetch(14'h025, 1'b0, "R9");

    // R8 release wins over global lock in the same write
    reg_write(12'h3E7, 8'h25);
    expect_fetch(14'h035, 1'b0, "R8");
    expect_fetch(14'h015, 1'b0, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule